// File: doc/BRIEF.md
# Bus read strobe to device handshake bridge

This controller sits between a bus master that requests a read with a level strobe and a local device that answers with its own acknowledge. When the bus strobe goes high, the controller strobes the device. Once the device acknowledges, the controller enables the read data and then acknowledges the bus. When the bus withdraws its strobe, the controller drops the data enable first. It then releases the device strobe and the bus acknowledge, and waits for the device acknowledge to return low before it accepts another read.

Both inputs come from outside the clock domain. Each passes through a two-flop synchronizer, and every output is a registered state-machine output. No output changes more than once per clock. A parameter selects how the two final releases are ordered: in the same cycle, bus acknowledge first, or device strobe first. This covers every order the handshake allows.

Top module: `rd_strobe_bridge`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `dev_stb_o`, `dat_en_o` and `bus_ack_o` are all 0.
- R2: From idle, `dev_stb_o` rises on the third rising clock edge after `bus_req_i` goes high. It rises only when the synchronized `dev_ack_i` is low and `bus_ack_o` is low.
- R3: `dat_en_o` rises on the third rising edge after `dev_ack_i` goes high, and only while `dev_stb_o` is high.
- R4: `bus_ack_o` rises exactly one clock after `dat_en_o` rises.
- R5: `dat_en_o` falls on the third rising edge after `bus_req_i` goes low. In that cycle `dev_stb_o` and `bus_ack_o` are both still high.
- R6: One clock after `dat_en_o` falls, the release order depends on `RELEASE_ORDER`. With 0, `dev_stb_o` and `bus_ack_o` both fall. With 1, `bus_ack_o` falls and `dev_stb_o` follows one clock later. With 2, `dev_stb_o` falls and `bus_ack_o` follows one clock later.
- R7: After a cycle, a `bus_req_i` held high starts no new read while `dev_ack_i` stays high. `dev_stb_o` then rises on the fourth rising edge after `dev_ack_i` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus read strobe, asynchronous |
| dev_ack_i | input | 1 | Local device acknowledge, asynchronous |
| dev_stb_o | output | 1 | Strobe to the local device |
| dat_en_o | output | 1 | Read data latch/drive enable |
| bus_ack_o | output | 1 | Data acknowledge to the bus |

## Verification
Two releases can fall in one clock: the device strobe and the bus acknowledge, both after the data enable drops. Three instances, one per `RELEASE_ORDER` value, share the same stimulus, so one withdrawal of the bus strobe produces all three orderings. Each instance is judged cycle by cycle against its own expected order. A monitor also flags any edge that breaks the data-enable-first rule or the strobe-before-enable rule.

// File: rtl/rd_strobe_bridge.sv
module rd_strobe_bridge #(
  parameter int RELEASE_ORDER = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_i,
  input  logic dev_ack_i,
  output logic dev_stb_o,
  output logic dat_en_o,
  output logic bus_ack_o
);

  typedef enum logic [2:0] {IDLE, WAIT_DEV, DRIVE, HOLD, RELEASE, DRAIN} state_t;

  state_t     st;
  logic [1:0] req_sync, ack_sync;
  logic       req_s, ack_s;

  assign req_s = req_sync[1];
  assign ack_s = ack_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      ack_sync <= '0;
    end else begin
      req_sync <= {req_sync[0], bus_req_i};
      ack_sync <= {ack_sync[0], dev_ack_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      dev_stb_o <= 1'b0;
      dat_en_o  <= 1'b0;
      bus_ack_o <= 1'b0;
    end else begin
      unique case (st)
        IDLE: if (req_s && !ack_s && !bus_ack_o) begin
          dev_stb_o <= 1'b1;
          st        <= WAIT_DEV;
        end
        WAIT_DEV: if (ack_s) begin
          dat_en_o <= 1'b1;
          st       <= DRIVE;
        end
        DRIVE: begin
          bus_ack_o <= 1'b1;
          st        <= HOLD;
        end
        HOLD: if (!req_s) begin
          dat_en_o <= 1'b0;
          st       <= RELEASE;
        end
        RELEASE: begin
          if (RELEASE_ORDER == 1) begin
            if (bus_ack_o) bus_ack_o <= 1'b0;
            else begin
              dev_stb_o <= 1'b0;
              st        <= DRAIN;
            end
          end else if (RELEASE_ORDER == 2) begin
            if (dev_stb_o) dev_stb_o <= 1'b0;
            else begin
              bus_ack_o <= 1'b0;
              st        <= DRAIN;
            end
          end else begin
            dev_stb_o <= 1'b0;
            bus_ack_o <= 1'b0;
            st        <= DRAIN;
          end
        end
        DRAIN: if (!ack_s && !bus_ack_o) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  p_start_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_stb_o) |-> !bus_ack_o && !dat_en_o && $past(req_s));

  p_enable_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_en_o) |-> dev_stb_o && $past(ack_s));

  p_ack_after_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack_o) |-> dat_en_o && $past(dat_en_o));

  p_enable_drops_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_en_o) |-> dev_stb_o && bus_ack_o && !$past(req_s));

  p_strobe_after_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_stb_o) |-> !dat_en_o);

  p_bus_first_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (RELEASE_ORDER == 1 && $fell(dev_stb_o)) |-> !bus_ack_o);

  p_dev_first_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (RELEASE_ORDER == 2 && $fell(bus_ack_o)) |-> !dev_stb_o);

endmodule

// File: tb/tb_rd_strobe_bridge.sv
module tb_rd_strobe_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic ack = 1'b0;
  logic [2:0] stb, den, bak;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rd_strobe_bridge #(.RELEASE_ORDER(0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req_i(req), .dev_ack_i(ack),
    .dev_stb_o(stb[0]), .dat_en_o(den[0]), .bus_ack_o(bak[0]));
  rd_strobe_bridge #(.RELEASE_ORDER(1)) dut_b (
    .clk(clk), .rst_n(rst_n), .bus_req_i(req), .dev_ack_i(ack),
    .dev_stb_o(stb[1]), .dat_en_o(den[1]), .bus_ack_o(bak[1]));
  rd_strobe_bridge #(.RELEASE_ORDER(2)) dut_l (
    .clk(clk), .rst_n(rst_n), .bus_req_i(req), .dev_ack_i(ack),
    .dev_stb_o(stb[2]), .dat_en_o(den[2]), .bus_ack_o(bak[2]));

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string tag, string what, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  logic [2:0] p_stb, p_den, p_bak;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 3; i++) begin
        if (den[i] && !p_den[i] && !stb[i]) begin
          checks++; errors++;
          $display("FAIL R3 inst %0d enable rose without strobe: actual 0 expected 1", i);
        end
        if (bak[i] && !p_bak[i] && !p_den[i]) begin
          checks++; errors++;
          $display("FAIL R4 inst %0d ack rose before enable: actual 0 expected 1", i);
        end
        if (!stb[i] && p_stb[i] && den[i]) begin
          checks++; errors++;
          $display("FAIL R5 inst %0d strobe fell with enable high: actual 1 expected 0", i);
        end
      end
    end
    p_stb = stb; p_den = den; p_bak = bak;
  end

  task automatic t_reset();
    rst_n = 1'b0;
    req = 1'b0;
    ack = 1'b0;
    step(2);
    chk("R1", "stb in reset", stb, 3'b000);
    chk("R1", "en/ack in reset", den | bak, 3'b000);
    rst_n = 1'b1;
    step(1);
    chk("R1", "outputs after reset", stb | den | bak, 3'b000);
  endtask

  task automatic t_read(int dev_delay, int hold);
    req = 1'b1;
    step(2);
    chk("R2", "stb before sync", stb, 3'b000);
    step(1);
    chk("R2", "stb rise", stb, 3'b111);
    chk("R2", "en low at start", den, 3'b000);
    step(dev_delay);
    chk("R3", "en waits for device", den, 3'b000);
    ack = 1'b1;
    step(2);
    chk("R3", "en before sync", den, 3'b000);
    step(1);
    chk("R3", "en rise", den, 3'b111);
    chk("R4", "ack not with en", bak, 3'b000);
    step(1);
    chk("R4", "ack rise", bak, 3'b111);
    step(hold);
    req = 1'b0;
    step(2);
    chk("R5", "en held before sync", den, 3'b111);
    step(1);
    chk("R5", "en fell", den, 3'b000);
    chk("R5", "stb still high", stb, 3'b111);
    chk("R5", "ack still high", bak, 3'b111);
    step(1);
    chk("R6", "stb after first release", stb, 3'b010);
    chk("R6", "ack after first release", bak, 3'b100);
    step(1);
    chk("R6", "stb after second release", stb, 3'b000);
    chk("R6", "ack after second release", bak, 3'b000);
    ack = 1'b0;
    step(6);
    chk("R7", "idle after device release", stb | den | bak, 3'b000);
  endtask

  task automatic t_early_request();
    req = 1'b1;
    step(3);
    ack = 1'b1;
    step(4);
    req = 1'b0;
    step(6);
    chk("R6", "released", stb | bak, 3'b000);
    req = 1'b1;
    step(8);
    chk("R7", "no start while device ack high", stb, 3'b000);
    ack = 1'b0;
    step(3);
    chk("R7", "stb before drain", stb, 3'b000);
    step(1);
    chk("R7", "stb rise after drain", stb, 3'b111);
    ack = 1'b1;
    step(4);
    req = 1'b0;
    step(6);
    ack = 1'b0;
    step(6);
    chk("R7", "idle at end", stb | den | bak, 3'b000);
  endtask

  initial begin
    t_reset();
    t_read(0, 0);
    t_read(5, 3);
    t_early_request();
    t_read(2, 7);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule